// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block stands between a system bus and a battery-backed 8K x 8 static memory. It watches two comparator flags that report the supply level: one says the supply is above the deselect threshold, the other says it is above the lower battery-switchover threshold (about 3 V). Both flags arrive asynchronously. Each one passes through a two-flop synchroniser and then a glitch filter before a four-state sequencer acts on it. The states are normal, protect, battery and recover.

When the supply leaves tolerance, the sequencer deselects the memory. It forces the chip-enable, write-enable and output-enable lines it forwards to their inactive level, and it stops driving the data bus. A write already under way is cut off in the same cycle. If the supply falls further, the battery-select output also asserts. When the supply returns, a recovery timer keeps the memory deselected for a set number of cycles before bus inputs are recognised again. A dip during that window restarts the count.

The recovery length, the filter length and the timing bounds are all parameters given in clock cycles. Elaboration checks that the recovery length sits inside the 40 ms to 200 ms window. It also checks that the worst-case deselect latency stays within the 200 µs limit.

Top module: `pwr_guard_seq`

## Requirements
- R1: After reset the block is in the recover state. Protect is 1, ready is 0, battery-select is 0 and all forwarded controls are 1 (inactive). Ready rises exactly REC_CYC rising edges after reset is released, provided both flags are 1.
- R2: While ready is 1, ce_n_o, we_n_o and oe_n_o equal ce_n_i, we_n_i and oe_n_i in the same cycle.
- R3: bus_dq_en_o is 1 exactly when ready is 1, ce_n_i is 0, oe_n_i is 0 and we_n_i is 1. While it is 1, bus_dq_o equals arr_rdata_i; otherwise bus_dq_o is all zeros.
- R4: When vok_i falls and stays low, protect_o and the deselection of the controls take effect on the FILT_CYC+3rd rising edge, and not before.
- R5: A low pulse on a supply flag that lasts fewer than FILT_CYC rising edges has no effect. A pulse of FILT_CYC edges is acted upon.
- R6: While protect is 1, all three forwarded controls are 1 and bus_dq_en_o is 0, whatever the control inputs.
- R7: A write in progress (ce_n_i = 0 and we_n_i = 0) is cut off: we_n_o goes to 1 in the same cycle that protect_o rises.
- R8: battery-select rises on the FILT_CYC+3rd edge after vbat_i falls. It falls FILT_CYC+3 edges after vbat_i returns; protect stays 1 while vok_i is still low.
- R9: After vok_i returns (with vbat_i high), ready rises on edge FILT_CYC+3+REC_CYC, counted from the change.
- R10: A supply dip accepted by the filter during recovery restarts the recovery count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vok_i | input | 1 | Async flag: supply above the deselect threshold |
| vbat_i | input | 1 | Async flag: supply above the battery-switchover threshold |
| ce_n_i | input | 1 | Chip enable from the bus, active low |
| we_n_i | input | 1 | Write enable from the bus, active low |
| oe_n_i | input | 1 | Output enable from the bus, active low |
| arr_rdata_i | input | DW | Read data from the memory array |
| ce_n_o | output | 1 | Gated chip enable to the array |
| we_n_o | output | 1 | Gated write enable to the array |
| oe_n_o | output | 1 | Gated output enable to the array |
| bus_dq_o | output | DW | Read data toward the bus |
| bus_dq_en_o | output | 1 | Bus drive enable (0 = high impedance) |
| protect_o | output | 1 | Write-protect / deselect active |
| batt_sel_o | output | 1 | Battery powers the array |
| ready_o | output | 1 | Bus inputs are recognised |

## Verification
The bench builds the block with FILT_CYC=3 and REC_CYC=40, bounded by REC_MIN_CYC=20, REC_MAX_CYC=100 and DESEL_MAX_CYC=8. With these values every filter, deselect and recovery edge can be sampled on the exact cycle. A dip can be placed deep inside a recovery window, so a timer that failed to restart would finish visibly early. Pulses of two and three edges sit on either side of the filter limit. Random control and data traffic runs in both the normal and the protected state.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

   typedef enum logic [1:0] {
      PG_NORMAL  = 2'd0,
      PG_PROTECT = 2'd1,
      PG_BATTERY = 2'd2,
      PG_RECOVER = 2'd3
   } pg_state_e;

   localparam int PG_NCH   = 2;
   localparam int PG_CH_OK = 0;
   localparam int PG_CH_BT = 1;

endpackage

// File: rtl/pwr_flag_filt.sv
module pwr_flag_filt #(
   parameter int NCH      = 2,
   parameter int FILT_CYC = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] raw_i,
   output logic [NCH-1:0] flt_o
);
   localparam int CW = $clog2(FILT_CYC + 1);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic s1, s2, f;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
         end else begin
            s1 <= raw_i[c];
            s2 <= s1;
         end
      end

      if (FILT_CYC == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) f <= 1'b1;
            else        f <= s2;
         end
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               f   <= 1'b1;
               cnt <= '0;
            end else if (s2 == f) begin
               cnt <= '0;
            end else if (cnt == CW'(FILT_CYC - 1)) begin
               f   <= s2;
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end

      assign flt_o[c] = f;
   end
endmodule

// File: rtl/pwr_rec_timer.sv
module pwr_rec_timer #(
   parameter int REC_CYC = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   localparam int CW = $clog2(REC_CYC + 1);

   logic [CW-1:0] cnt;
   logic          at_end;

   assign at_end = (cnt == CW'(REC_CYC - 1));
   assign done_o = run_i && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (!run_i)          cnt <= '0;
      else if (!at_end)         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pwr_guard_fsm.sv
module pwr_guard_fsm
   import pwr_guard_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      vok_f_i,
   input  logic      vbat_f_i,
   input  logic      rec_done_i,
   output pg_state_e state_o
);
   pg_state_e st, nx;

   always_comb begin
      nx = st;
      unique case (st)
         PG_NORMAL: begin
            if (!vbat_f_i)      nx = PG_BATTERY;
            else if (!vok_f_i)  nx = PG_PROTECT;
         end
         PG_PROTECT: begin
            if (!vbat_f_i)      nx = PG_BATTERY;
            else if (vok_f_i)   nx = PG_RECOVER;
         end
         PG_BATTERY: begin
            if (vbat_f_i)       nx = vok_f_i ? PG_RECOVER : PG_PROTECT;
         end
         PG_RECOVER: begin
            if (!vbat_f_i)      nx = PG_BATTERY;
            else if (!vok_f_i)  nx = PG_PROTECT;
            else if (rec_done_i) nx = PG_NORMAL;
         end
         default:               nx = PG_RECOVER;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= PG_RECOVER;
      else        st <= nx;
   end

   assign state_o = st;
endmodule

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq
   import pwr_guard_pkg::*;
#(
   parameter int DW            = 8,
   parameter int FILT_CYC      = 8,
   parameter int REC_CYC       = 100000,
   parameter int REC_MIN_CYC   = 40000,
   parameter int REC_MAX_CYC   = 200000,
   parameter int DESEL_MAX_CYC = 200
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vok_i,
   input  logic          vbat_i,
   input  logic          ce_n_i,
   input  logic          we_n_i,
   input  logic          oe_n_i,
   input  logic [DW-1:0] arr_rdata_i,
   output logic          ce_n_o,
   output logic          we_n_o,
   output logic          oe_n_o,
   output logic [DW-1:0] bus_dq_o,
   output logic          bus_dq_en_o,
   output logic          protect_o,
   output logic          batt_sel_o,
   output logic          ready_o
);
   localparam int DESEL_LAT = FILT_CYC + 3;

   if (DW < 1) begin : g_bad_dw
      $error("pwr_guard_seq: DW must be at least 1");
   end
   if (FILT_CYC < 1) begin : g_bad_filt
      $error("pwr_guard_seq: FILT_CYC must be at least 1");
   end
   if (REC_CYC < REC_MIN_CYC || REC_CYC > REC_MAX_CYC) begin : g_bad_rec
      $error("pwr_guard_seq: REC_CYC outside recovery window");
   end
   if (DESEL_LAT > DESEL_MAX_CYC) begin : g_bad_lat
      $error("pwr_guard_seq: deselect latency exceeds bound");
   end

   logic [PG_NCH-1:0] raw, flt;
   logic              rec_done;
   pg_state_e         state;
   logic              access_ok;

   assign raw[PG_CH_OK] = vok_i;
   assign raw[PG_CH_BT] = vbat_i;

   pwr_flag_filt #(.NCH(PG_NCH), .FILT_CYC(FILT_CYC)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw),
      .flt_o (flt)
   );

   pwr_rec_timer #(.REC_CYC(REC_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state == PG_RECOVER),
      .done_o (rec_done)
   );

   pwr_guard_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .vok_f_i    (flt[PG_CH_OK]),
      .vbat_f_i   (flt[PG_CH_BT]),
      .rec_done_i (rec_done),
      .state_o    (state)
   );

   assign access_ok  = (state == PG_NORMAL);
   assign ready_o    = access_ok;
   assign protect_o  = !access_ok;
   assign batt_sel_o = (state == PG_BATTERY);

   // gating is combinational so a running write is cut in the protect cycle
   assign ce_n_o = ce_n_i | !access_ok;
   assign we_n_o = we_n_i | !access_ok;
   assign oe_n_o = oe_n_i | !access_ok;

   assign bus_dq_en_o = access_ok && !ce_n_i && !oe_n_i && we_n_i;
   assign bus_dq_o    = bus_dq_en_o ? arr_rdata_i : '0;
endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk #(
   parameter int FILT_CYC = 8,
   parameter int REC_CYC  = 100000
) (
   input logic clk,
   input logic rst_n,
   input logic vok_i,
   input logic vbat_i,
   input logic ce_n_i,
   input logic we_n_i,
   input logic oe_n_i,
   input logic ce_n_o,
   input logic we_n_o,
   input logic oe_n_o,
   input logic bus_dq_en_o,
   input logic protect_o,
   input logic batt_sel_o,
   input logic ready_o
);
   localparam int LAT = FILT_CYC + 3;
   localparam int LW  = $clog2(LAT + 1);
   localparam int RW  = $clog2(REC_CYC + 1);

   logic [LW-1:0] ok_lo, bt_lo;
   logic [RW-1:0] prot_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ok_lo    <= '0;
         bt_lo    <= '0;
         prot_run <= '0;
      end else begin
         ok_lo    <= vok_i  ? '0 : ((ok_lo == LW'(LAT)) ? ok_lo : ok_lo + 1'b1);
         bt_lo    <= vbat_i ? '0 : ((bt_lo == LW'(LAT)) ? bt_lo : bt_lo + 1'b1);
         prot_run <= !protect_o ? '0 :
                     ((prot_run == RW'(REC_CYC)) ? prot_run : prot_run + 1'b1);
      end
   end

   p_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_lo >= LW'(LAT - 1) && !vok_i) |=> protect_o);

   p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      protect_o |-> (ce_n_o && we_n_o && oe_n_o && !bus_dq_en_o));

   p_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dq_en_o |-> (ready_o && !ce_n_i && !oe_n_i && we_n_i));

   p_batt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((bt_lo >= LW'(LAT - 1) && !vbat_i) |=> batt_sel_o));

   p_batt_prot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      batt_sel_o |-> protect_o);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(protect_o) |-> (prot_run >= RW'(REC_CYC)));
endmodule

bind pwr_guard_seq pwr_guard_chk #(.FILT_CYC(FILT_CYC), .REC_CYC(REC_CYC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .vok_i       (vok_i),
   .vbat_i      (vbat_i),
   .ce_n_i      (ce_n_i),
   .we_n_i      (we_n_i),
   .oe_n_i      (oe_n_i),
   .ce_n_o      (ce_n_o),
   .we_n_o      (we_n_o),
   .oe_n_o      (oe_n_o),
   .bus_dq_en_o (bus_dq_en_o),
   .protect_o   (protect_o),
   .batt_sel_o  (batt_sel_o),
   .ready_o     (ready_o)
);

// File: tb/test_pwr_guard_seq.sv
module test_pwr_guard_seq;
   localparam int DW   = 8;
   localparam int FILT = 3;
   localparam int REC  = 40;
   localparam int LAT  = FILT + 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          vok_i = 1'b1, vbat_i = 1'b1;
   logic          ce_n_i = 1'b1, we_n_i = 1'b1, oe_n_i = 1'b1;
   logic [DW-1:0] arr_rdata_i = '0;
   logic          ce_n_o, we_n_o, oe_n_o, bus_dq_en_o, protect_o, batt_sel_o, ready_o;
   logic [DW-1:0] bus_dq_o;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   pwr_guard_seq #(
      .DW(DW), .FILT_CYC(FILT), .REC_CYC(REC),
      .REC_MIN_CYC(20), .REC_MAX_CYC(100), .DESEL_MAX_CYC(8)
   ) i_pwr_guard_seq (
      .clk(clk), .rst_n(rst_n), .vok_i(vok_i), .vbat_i(vbat_i),
      .ce_n_i(ce_n_i), .we_n_i(we_n_i), .oe_n_i(oe_n_i), .arr_rdata_i(arr_rdata_i),
      .ce_n_o(ce_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o),
      .bus_dq_o(bus_dq_o), .bus_dq_en_o(bus_dq_en_o),
      .protect_o(protect_o), .batt_sel_o(batt_sel_o), .ready_o(ready_o)
   );

   function automatic logic exp_en(input logic rdy, input logic ce, input logic we, input logic oe);
      return rdy && !ce && !oe && we;
   endfunction

   function automatic logic [2:0] exp_ctl(input logic rdy, input logic ce, input logic we, input logic oe);
      return rdy ? {ce, we, oe} : 3'b111;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_bus(input logic rdy, input string req);
      logic [2:0] ec;
      logic       ee;
      ec = exp_ctl(rdy, ce_n_i, we_n_i, oe_n_i);
      ee = exp_en(rdy, ce_n_i, we_n_i, oe_n_i);
      chk({ce_n_o, we_n_o, oe_n_o} == ec, req, int'({ce_n_o, we_n_o, oe_n_o}), int'(ec));
      chk(bus_dq_en_o == ee, req, int'(bus_dq_en_o), int'(ee));
      chk(bus_dq_o == (ee ? arr_rdata_i : '0), req, int'(bus_dq_o),
          int'(ee ? arr_rdata_i : 8'h00));
   endtask

   task automatic rand_bus();
      ce_n_i      = 1'($urandom_range(0, 1));
      we_n_i      = 1'($urandom_range(0, 1));
      oe_n_i      = 1'($urandom_range(0, 1));
      arr_rdata_i = DW'($urandom);
   endtask

   initial begin
      #(20 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      ce_n_i = 1'b0; we_n_i = 1'b0; oe_n_i = 1'b0;
      tick(3);
      // R1: reset state
      chk(protect_o == 1'b1, "R1 protect in reset", int'(protect_o), 1);
      chk(ready_o == 1'b0, "R1 ready in reset", int'(ready_o), 0);
      chk(batt_sel_o == 1'b0, "R1 batt in reset", int'(batt_sel_o), 0);
      chk({ce_n_o, we_n_o, oe_n_o} == 3'b111, "R1 controls in reset", int'({ce_n_o, we_n_o, oe_n_o}), 7);
      rst_n = 1'b1;
      tick(REC - 1);
      chk(ready_o == 1'b0, "R1 ready before recovery end", int'(ready_o), 0);
      tick(1);
      chk(ready_o == 1'b1, "R1 ready after recovery", int'(ready_o), 1);

      // R2 / R3: random traffic in normal state
      for (int i = 0; i < 200; i++) begin
         rand_bus();
         #1;
         chk_bus(1'b1, "R2 R3 normal traffic");
         tick(1);
      end

      // R4 / R7: write in progress, supply falls
      ce_n_i = 1'b0; we_n_i = 1'b0; oe_n_i = 1'b1;
      vok_i = 1'b0;
      tick(LAT - 1);
      chk(protect_o == 1'b0, "R4 no early protect", int'(protect_o), 0);
      chk(we_n_o == 1'b0, "R7 write still active", int'(we_n_o), 0);
      tick(1);
      chk(protect_o == 1'b1, "R4 protect on time", int'(protect_o), 1);
      chk(we_n_o == 1'b1, "R7 write cut off", int'(we_n_o), 1);

      // R6: random traffic while protected
      for (int i = 0; i < 50; i++) begin
         rand_bus();
         #1;
         chk_bus(1'b0, "R6 protected traffic");
         tick(1);
      end

      // R8: battery switchover and return
      vbat_i = 1'b0;
      tick(LAT - 1);
      chk(batt_sel_o == 1'b0, "R8 no early batt", int'(batt_sel_o), 0);
      tick(1);
      chk(batt_sel_o == 1'b1, "R8 batt on", int'(batt_sel_o), 1);
      vbat_i = 1'b1;
      tick(LAT);
      chk(batt_sel_o == 1'b0, "R8 batt off", int'(batt_sel_o), 0);
      chk(protect_o == 1'b1, "R8 still protected", int'(protect_o), 1);

      // R9: recovery after supply returns
      vok_i = 1'b1;
      tick(LAT + REC - 1);
      chk(ready_o == 1'b0, "R9 ready held off", int'(ready_o), 0);
      tick(1);
      chk(ready_o == 1'b1, "R9 ready on time", int'(ready_o), 1);

      // R5: short glitch ignored, FILT-length pulse accepted
      vok_i = 1'b0; tick(FILT - 1); vok_i = 1'b1;
      for (int i = 0; i < 20; i++) begin
         tick(1);
         chk(protect_o == 1'b0, "R5 short glitch ignored", int'(protect_o), 0);
      end
      vok_i = 1'b0; tick(FILT); vok_i = 1'b1;
      tick(LAT - FILT);
      chk(protect_o == 1'b1, "R5 full pulse accepted", int'(protect_o), 1);

      // R10: dip deep in recovery restarts the count
      tick(20);
      chk(ready_o == 1'b0, "R10 in recovery", int'(ready_o), 0);
      vok_i = 1'b0; tick(FILT); vok_i = 1'b1;
      tick(LAT + FILT + REC - FILT - 1);
      chk(ready_o == 1'b0, "R10 timer restarted", int'(ready_o), 0);
      tick(1);
      chk(ready_o == 1'b1, "R10 ready after restart", int'(ready_o), 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule